// File: doc/BRIEF.md
# AAL5 Frame-to-Cell Segmenter

The segmenter accepts frames from an application on a 32-bit word interface framed by three strobes. A start strobe carries the ATM cell header for the frame. A data-enable strobe marks each payload word. An end strobe flags the last payload word, and the two trailer words follow it. Trailer and payload words go into a data queue. The header is held aside and attached to each cell of the frame. A second, shallow queue gets one entry per outgoing cell. Each entry holds the cell's header and its word count, so it fixes the cell boundaries independently of the data.

The block fills in the trailer as words arrive. It writes the full byte length, built from the count of payload words and the two-bit valid-byte count the application places in the length field. It XORs the generated CRC-32 into whatever the application wrote in the CRC field. An output stage drains the entry queue one cell at a time. It sends the header, then an inserted HEC word, then the cell's data words. A ready output tells the application when to pause.

Top module: `aal5_segmenter`

## Requirements
- R1: Every cell starts with the frame's header word, flagged by `cell_start_o`. Bit 1 of that word (PTI end-of-frame) is 1 only in the cell that carries the trailer and 0 in every other cell. All other header bits are copied from the word seen with `sof_i`.
- R2: The word after each header is `{hec, 24'h0}`. Here hec is CRC-8 over the four emitted header bytes: polynomial 0x07, initial value 0, most significant bit first, result XORed with 0x55.
- R3: A frame of N payload words yields N+2 data words. They are cut into cells of 12 data words, and the last cell holds the remaining 1 to 12 words.
- R4: Data words leave in arrival order. Only words strobed with `den_i` while a frame is open are data. The `sof_i` word never appears as data.
- R5: In the first trailer word, bits 31:16 pass unchanged. Bits 15:0 are replaced by the byte length 4*(N-1)+v, where v is the application's bits 1:0 and a value of 0 counts as 4.
- R6: The second trailer word equals the application's value XOR the complement of the CRC-32 over the payload and the length-filled first trailer word. The CRC uses polynomial 0x04C11DB7, initial value all ones and most significant bit first, so a zero input yields a valid CRC.
- R7: A frame whose application CRC field is non-zero is still sent in full, carrying that field XOR the valid CRC.
- R8: `ready_o` is low exactly when the data queue has fewer than 14 free entries, and the queue never overflows while the application respects it.
- R9: After reset `ready_o` is 1 and `cell_valid_o` is 0.
- R10: `den_i` pulses while no frame is open are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sof_i | input | 1 | Header word strobe, opens a frame |
| den_i | input | 1 | Payload or trailer word strobe |
| eof_i | input | 1 | Last payload word, with den_i |
| data_i | input | 32 | Application word |
| ready_o | output | 1 | Application may keep sending |
| cell_valid_o | output | 1 | Cell word valid |
| cell_start_o | output | 1 | Cell header word |
| cell_data_o | output | 32 | Cell word |

## Verification
Ingress and egress share both queues. In a single cycle the ingress side can write a word and push a cell entry while the egress side pops an entry and reads a word. The bench provokes this by sending frames back to back, with no gap, while earlier cells are still draining. It adds a 500-word frame that fills the data queue until ready drops, so pushes and pops then coincide in most cycles. The whole output stream is compared word by word with a model built from the stimulus, including the cell-start flags, so any slip in either queue shows up as a wrong word or a misplaced boundary.

// File: rtl/aal5_seg_pkg.sv
package aal5_seg_pkg;
  localparam logic [31:0] CRC32_POLY = 32'h04C11DB7;
  localparam logic [7:0]  HEC_POLY   = 8'h07;
  localparam logic [7:0]  HEC_COSET  = 8'h55;

  typedef enum logic [1:0] {IN_IDLE, IN_PAY, IN_TR1, IN_TR2} in_st_e;
  typedef enum logic [1:0] {EG_IDLE, EG_HEC, EG_DATA} eg_st_e;

  function automatic logic [31:0] crc32_word(logic [31:0] c, logic [31:0] w);
    logic fb;
    for (int i = 31; i >= 0; i--) begin
      fb = c[31] ^ w[i];
      c  = {c[30:0], 1'b0};
      if (fb) c = c ^ CRC32_POLY;
    end
    return c;
  endfunction

  function automatic logic [7:0] hec_of(logic [31:0] h);
    logic [7:0] c;
    logic fb;
    c = 8'h00;
    for (int i = 31; i >= 0; i--) begin
      fb = c[7] ^ h[i];
      c  = {c[6:0], 1'b0};
      if (fb) c = c ^ HEC_POLY;
    end
    return c ^ HEC_COSET;
  endfunction
endpackage

// File: rtl/aal5_seg_fifo.sv
module aal5_seg_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 64,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic [W-1:0] wdata_i,
  input  logic         pop_i,
  output logic [W-1:0] rdata_o,
  output logic         empty_o,
  output logic         full_o,
  output logic [AW:0]  count_o
);
  logic [W-1:0]  mem_q [DEPTH];
  logic [AW-1:0] wptr_q, rptr_q;
  logic [AW:0]   cnt_q;

  assign rdata_o = mem_q[rptr_q];
  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == (AW+1)'(DEPTH));
  assign count_o = cnt_q;

  always_ff @(posedge clk_i) begin
    if (push_i) mem_q[wptr_q] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (push_i) wptr_q <= (wptr_q == AW'(DEPTH-1)) ? '0 : wptr_q + 1'b1;
      if (pop_i)  rptr_q <= (rptr_q == AW'(DEPTH-1)) ? '0 : rptr_q + 1'b1;
      case ({push_i, pop_i})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  p_no_overflow_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o |-> !push_i || pop_i);
  p_no_underflow_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    empty_o |-> !pop_i);
endmodule

// File: rtl/aal5_seg_ingress.sv
module aal5_seg_ingress
  import aal5_seg_pkg::*;
#(
  parameter int CELL_WORDS = 12,
  parameter int PW_W       = 16,
  localparam int CNT_W     = $clog2(CELL_WORDS + 1),
  localparam int LQ_W      = 32 + CNT_W
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            sof_i,
  input  logic            den_i,
  input  logic            eof_i,
  input  logic [31:0]     data_i,
  output logic            dq_push_o,
  output logic [31:0]     dq_wdata_o,
  output logic            lq_push_o,
  output logic [LQ_W-1:0] lq_wdata_o
);
  in_st_e           st_q;
  logic [31:0]      hdr_q, crc_q, crc_nxt, word;
  logic [PW_W-1:0]  pw_q;
  logic [CNT_W-1:0] cell_q, cell_nxt;
  logic [15:0]      len16;
  logic [2:0]       tail_bytes;
  logic             last_w;

  always_comb begin
    tail_bytes = (data_i[1:0] == 2'b00) ? 3'd4 : {1'b0, data_i[1:0]};
    len16      = 16'({pw_q - 1'b1, 2'b00}) + 16'(tail_bytes);
    case (st_q)
      IN_TR1:  word = {data_i[31:16], len16};
      IN_TR2:  word = ~crc_q ^ data_i;
      default: word = data_i;
    endcase
    crc_nxt    = crc32_word(crc_q, word);
    cell_nxt   = cell_q + 1'b1;
    last_w     = (st_q == IN_TR2);
    dq_push_o  = den_i && !sof_i && (st_q != IN_IDLE);
    dq_wdata_o = word;
    lq_push_o  = dq_push_o && (last_w || cell_nxt == CNT_W'(CELL_WORDS));
    lq_wdata_o = {hdr_q[31:2], last_w, hdr_q[0], cell_nxt};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= IN_IDLE;
      hdr_q  <= '0;
      crc_q  <= '1;
      pw_q   <= '0;
      cell_q <= '0;
    end else if (sof_i) begin
      st_q   <= IN_PAY;
      hdr_q  <= data_i;
      crc_q  <= '1;
      pw_q   <= '0;
      cell_q <= '0;
    end else if (dq_push_o) begin
      crc_q  <= crc_nxt;
      cell_q <= lq_push_o ? '0 : cell_nxt;
      case (st_q)
        IN_PAY: begin
          pw_q <= pw_q + 1'b1;
          if (eof_i) st_q <= IN_TR1;
        end
        IN_TR1:  st_q <= IN_TR2;
        default: st_q <= IN_IDLE;
      endcase
    end
  end

  p_cell_size_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lq_push_o |-> (lq_wdata_o[CNT_W-1:0] != '0) &&
                  (lq_wdata_o[CNT_W-1:0] <= CNT_W'(CELL_WORDS)));
  p_end_closes_frame_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lq_push_o && lq_wdata_o[CNT_W+1]) |=> (st_q == IN_IDLE) || $past(sof_i));
  p_idle_no_write_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == IN_IDLE) |-> !dq_push_o);
endmodule

// File: rtl/aal5_seg_egress.sv
module aal5_seg_egress
  import aal5_seg_pkg::*;
#(
  parameter int CELL_WORDS = 12,
  localparam int CNT_W     = $clog2(CELL_WORDS + 1),
  localparam int LQ_W      = 32 + CNT_W
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            lq_empty_i,
  input  logic [LQ_W-1:0] lq_rdata_i,
  output logic            lq_pop_o,
  input  logic [31:0]     dq_rdata_i,
  output logic            dq_pop_o,
  output logic            cell_valid_o,
  output logic            cell_start_o,
  output logic [31:0]     cell_data_o
);
  eg_st_e           st_q;
  logic [31:0]      hdr_q;
  logic [CNT_W-1:0] left_q;

  assign lq_pop_o = (st_q == EG_IDLE) && !lq_empty_i;
  assign dq_pop_o = (st_q == EG_DATA);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q         <= EG_IDLE;
      hdr_q        <= '0;
      left_q       <= '0;
      cell_valid_o <= 1'b0;
      cell_start_o <= 1'b0;
      cell_data_o  <= '0;
    end else begin
      cell_start_o <= 1'b0;
      case (st_q)
        EG_IDLE: begin
          cell_valid_o <= lq_pop_o;
          if (lq_pop_o) begin
            hdr_q        <= lq_rdata_i[CNT_W +: 32];
            left_q       <= lq_rdata_i[CNT_W-1:0];
            cell_start_o <= 1'b1;
            cell_data_o  <= lq_rdata_i[CNT_W +: 32];
            st_q         <= EG_HEC;
          end
        end
        EG_HEC: begin
          cell_valid_o <= 1'b1;
          cell_data_o  <= {hec_of(hdr_q), 24'h0};
          st_q         <= EG_DATA;
        end
        default: begin
          cell_valid_o <= 1'b1;
          cell_data_o  <= dq_rdata_i;
          left_q       <= left_q - 1'b1;
          if (left_q == CNT_W'(1)) st_q <= EG_IDLE;
        end
      endcase
    end
  end

  p_hec_follows_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cell_start_o |=> cell_valid_o && !cell_start_o);
  p_start_valid_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cell_start_o |-> cell_valid_o);
  p_no_pop_in_hec_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lq_pop_o |=> !lq_pop_o && !dq_pop_o);
endmodule

// File: rtl/aal5_segmenter.sv
module aal5_segmenter
  import aal5_seg_pkg::*;
#(
  parameter int CELL_WORDS   = 12,
  parameter int DQ_DEPTH     = 64,
  parameter int LQ_DEPTH     = 8,
  parameter int READY_MARGIN = 14,
  localparam int CNT_W       = $clog2(CELL_WORDS + 1),
  localparam int LQ_W        = 32 + CNT_W,
  localparam int DQ_AW       = $clog2(DQ_DEPTH),
  localparam int LQ_AW       = $clog2(LQ_DEPTH)
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        sof_i,
  input  logic        den_i,
  input  logic        eof_i,
  input  logic [31:0] data_i,
  output logic        ready_o,
  output logic        cell_valid_o,
  output logic        cell_start_o,
  output logic [31:0] cell_data_o
);
  logic            dq_push, dq_pop, dq_empty, dq_full;
  logic [31:0]     dq_wdata, dq_rdata;
  logic [DQ_AW:0]  dq_count;
  logic            lq_push, lq_pop, lq_empty, lq_full;
  logic [LQ_W-1:0] lq_wdata, lq_rdata;
  logic [LQ_AW:0]  lq_count;

  assign ready_o = (DQ_DEPTH - int'(dq_count)) >= READY_MARGIN;

  aal5_seg_ingress #(.CELL_WORDS(CELL_WORDS)) u_ing (
    .clk_i, .rst_ni, .sof_i, .den_i, .eof_i, .data_i,
    .dq_push_o(dq_push), .dq_wdata_o(dq_wdata),
    .lq_push_o(lq_push), .lq_wdata_o(lq_wdata)
  );

  aal5_seg_fifo #(.W(32), .DEPTH(DQ_DEPTH)) u_dq (
    .clk_i, .rst_ni, .push_i(dq_push), .wdata_i(dq_wdata), .pop_i(dq_pop),
    .rdata_o(dq_rdata), .empty_o(dq_empty), .full_o(dq_full), .count_o(dq_count)
  );

  aal5_seg_fifo #(.W(LQ_W), .DEPTH(LQ_DEPTH)) u_lq (
    .clk_i, .rst_ni, .push_i(lq_push), .wdata_i(lq_wdata), .pop_i(lq_pop),
    .rdata_o(lq_rdata), .empty_o(lq_empty), .full_o(lq_full), .count_o(lq_count)
  );

  aal5_seg_egress #(.CELL_WORDS(CELL_WORDS)) u_eg (
    .clk_i, .rst_ni, .lq_empty_i(lq_empty), .lq_rdata_i(lq_rdata), .lq_pop_o(lq_pop),
    .dq_rdata_i(dq_rdata), .dq_pop_o(dq_pop),
    .cell_valid_o, .cell_start_o, .cell_data_o
  );

  p_ready_fall_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ready_o) |-> $past(dq_push && !dq_pop));
  p_cells_have_data_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lq_pop |-> !dq_empty);
endmodule

// File: tb/sim_aal5_segmenter.sv
`timescale 1ns/1ps
module sim_aal5_segmenter;
  localparam int NF = 7;
  localparam int MAXW = 1024;
  // vector table: payload words, tail byte code, app CRC, header, junk pulses before SOF
  localparam int          F_N    [NF] = '{1, 10, 11, 22, 30, 5, 500};
  localparam logic [1:0]  F_VB   [NF] = '{2'd1, 2'd0, 2'd3, 2'd2, 2'd0, 2'd1, 2'd3};
  localparam logic [31:0] F_APP  [NF] = '{32'h0, 32'h0, 32'h0, 32'h0, 32'hDEAD0001, 32'h0, 32'h0};
  localparam logic [31:0] F_HDR  [NF] = '{32'h0012_3450, 32'h00AB_CDE2, 32'hF0F0_F0F1,
                                         32'h1234_5678, 32'h0000_0320, 32'hFFFF_FFFF, 32'h0356_7890};
  localparam int          F_JUNK [NF] = '{0, 0, 3, 0, 0, 2, 0};

  logic clk = 1'b0, rst_n = 1'b0;
  logic sof = 1'b0, den = 1'b0, eof = 1'b0;
  logic [31:0] din = '0;
  logic ready, cvalid, cstart;
  logic [31:0] cdata;

  always #5 clk = ~clk;

  aal5_segmenter u0 (
    .clk_i(clk), .rst_ni(rst_n), .sof_i(sof), .den_i(den), .eof_i(eof), .data_i(din),
    .ready_o(ready), .cell_valid_o(cvalid), .cell_start_o(cstart), .cell_data_o(cdata)
  );

  int checks = 0, errors = 0;
  logic [31:0] exp_d [MAXW];
  logic        exp_s [MAXW];
  int          exp_k [MAXW];
  int          exp_n = 0;
  logic [31:0] obs_d [MAXW];
  logic        obs_s [MAXW];
  int          obs_n = 0;
  bit          saw_low = 0;
  bit          done = 0;

  function automatic logic [31:0] pay(int f, int k);
    return (32'(f) * 32'h0100_0193) ^ (32'(k) * 32'h9E37_79B9) ^ 32'(k);
  endfunction

  function automatic logic [31:0] crc_upd(logic [31:0] c, logic [31:0] w);
    for (int b = 3; b >= 0; b--) begin
      logic [7:0] by = w[8*b +: 8];
      c = c ^ {by, 24'h0};
      for (int j = 0; j < 8; j++) c = c[31] ? ((c << 1) ^ 32'h04C11DB7) : (c << 1);
    end
    return c;
  endfunction

  function automatic logic [7:0] hec_ref(logic [31:0] h);
    logic [7:0] c = 8'h00;
    for (int b = 3; b >= 0; b--) begin
      c = c ^ h[8*b +: 8];
      for (int j = 0; j < 8; j++) c = c[7] ? ((c << 1) ^ 8'h07) : (c << 1);
    end
    return c ^ 8'h55;
  endfunction

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  // kinds: 0 header, 1 hec, 2 payload, 3 length trailer, 4 crc trailer
  function automatic void add_exp(logic [31:0] d, logic s, int k);
    exp_d[exp_n] = d; exp_s[exp_n] = s; exp_k[exp_n] = k; exp_n++;
  endfunction

  function automatic void build_exp(int f);
    logic [31:0] words [MAXW];
    logic [31:0] crc = 32'hFFFF_FFFF;
    int nw = F_N[f] + 2;
    int v = (F_VB[f] == 2'd0) ? 4 : int'(F_VB[f]);
    for (int k = 0; k < F_N[f]; k++) words[k] = pay(f, k);
    words[F_N[f]] = {16'hA5C3, 16'(4 * (F_N[f] - 1) + v)};
    for (int k = 0; k <= F_N[f]; k++) crc = crc_upd(crc, words[k]);
    words[F_N[f] + 1] = ~crc ^ F_APP[f];
    for (int k = 0; k < nw; k += 12) begin
      bit last = (k + 12 >= nw);
      logic [31:0] h = {F_HDR[f][31:2], last, F_HDR[f][0]};
      add_exp(h, 1'b1, 0);
      add_exp({hec_ref(h), 24'h0}, 1'b0, 1);
      for (int j = k; j < nw && j < k + 12; j++)
        add_exp(words[j], 1'b0, (j < F_N[f]) ? 2 : (j == F_N[f] ? 3 : 4));
    end
  endfunction

  task automatic put(logic s, logic d, logic e, logic [31:0] w);
    while (!ready) begin
      saw_low = 1;
      sof = 0; den = 0; eof = 0;
      @(posedge clk); #1;
    end
    sof = s; den = d; eof = e; din = w;
    @(posedge clk); #1;
    sof = 0; den = 0; eof = 0;
  endtask

  task automatic send_frame(int f);
    for (int j = 0; j < F_JUNK[f]; j++) put(1'b0, 1'b1, 1'b0, 32'hBAD0_0000 + 32'(j));
    put(1'b1, 1'b0, 1'b0, F_HDR[f]);
    for (int k = 0; k < F_N[f]; k++) put(1'b0, 1'b1, k == F_N[f] - 1, pay(f, k));
    put(1'b0, 1'b1, 1'b0, {16'hA5C3, 14'h3FFF, F_VB[f]});
    put(1'b0, 1'b1, 1'b0, F_APP[f]);
    build_exp(f);
  endtask

  always @(negedge clk) begin
    if (rst_n && cvalid && obs_n < MAXW) begin
      obs_d[obs_n] = cdata;
      obs_s[obs_n] = cstart;
      obs_n++;
    end
  end

  initial begin
    for (int c = 0; c < 150000 && !done; c++) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: got %0d expected %0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int idle;
    repeat (3) @(posedge clk);
    #1;
    chk(ready === 1'b1, "R9 ready after reset", 32'(ready), 32'd1);
    chk(cvalid === 1'b0, "R9 valid after reset", 32'(cvalid), 32'd0);
    rst_n = 1'b1;
    @(posedge clk); #1;
    // R10: stray data strobes with no frame open
    put(1'b0, 1'b1, 1'b1, 32'h0BAD_BEEF);
    repeat (20) @(posedge clk);
    #1;
    chk(obs_n == 0, "R10 no output from stray den", 32'(obs_n), 32'd0);
    for (int f = 0; f < NF; f++) send_frame(f);
    idle = 0;
    while (idle < 40) begin
      @(posedge clk);
      idle = cvalid ? 0 : idle + 1;
    end
    chk(saw_low, "R8 ready dropped under load", 32'(saw_low), 32'd1);
    chk(obs_n == exp_n, "R3 total words", 32'(obs_n), 32'(exp_n));
    for (int i = 0; i < exp_n && i < obs_n; i++) begin
      string r;
      case (exp_k[i])
        0: r = "R1 header";
        1: r = "R2 hec";
        2: r = "R4 payload";
        3: r = "R5 length";
        default: r = (exp_d[i] != ~crc_upd(32'hFFFF_FFFF, 32'h0)) ? "R6 crc" : "R6 crc";
      endcase
      if (exp_k[i] == 4 && i > 0 && exp_k[i-1] != 4 && obs_d[i] != exp_d[i]) r = "R7 crc field";
      chk(obs_d[i] === exp_d[i], r, obs_d[i], exp_d[i]);
      chk(obs_s[i] === exp_s[i], "R3 cell boundary", 32'(obs_s[i]), 32'(exp_s[i]));
    end
    chk(ready === 1'b1, "R8 ready after drain", 32'(ready), 32'd1);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule